// File: doc/BRIEF.md
# Windowed Parallel-Prefix State Machine Evaluator

This block runs a finite-state machine over a window of W input symbols in a single clock cycle. For every symbol it first writes out a small lookup table that gives the next state for each possible current state under that symbol. It then merges neighbouring tables in a logarithmic prefix network: each merged table is filled by looking up the later table with every entry of the earlier one. After log2(W) levels, position i holds one table that covers symbols 0 through i. Each of those tables is then looked up with the registered start state.

The result is the machine's state after every symbol of the window, together with an accept flag per position. When the window is marked valid, the state after the last symbol becomes the start state for the next window. The transition table and the set of accepting states are parameters. The method needs a symbol stream that does not depend on the machine's own outputs, and it assumes such a stream.

Top module: `pfsm_window`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `start_state` to 0.
- R2: The state reported for position 0 equals `TRANS(start_state, sym0)`. Symbol i is `in_syms[i*AW +: AW]`, and the state for position i is `pos_state[i*SW +: SW]`. Entry (s, a) of the transition table is `TRANS[(s*2**AW + a)*SW +: SW]`.
- R3: For every position i > 0, the state reported there equals `TRANS(state of position i-1, symbol i)`. This holds in the same cycle as the inputs, without waiting for any clock edge.
- R4: `pos_accept[i]` is 1 exactly when bit s of `ACCEPT` is 1, where s is the state of position i.
- R5: At a rising edge with `in_valid` high and `rst` low, `start_state` takes the state of position W-1.
- R6: At a rising edge with `in_valid` low and `rst` low, `start_state` holds its value, whatever the symbols are.
- R7: When `rst` and `in_valid` are both high at an edge, the reset wins and `start_state` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window qualifier; when high at an edge, the start state advances |
| in_syms | input | W*AW | W symbols; position 0 is in the least significant bits |
| pos_state | output | W*SW | State after each position; position 0 is in the least significant bits |
| pos_accept | output | W | Accept flag for each position |
| start_state | output | SW | Registered state that enters the current window |

## Verification
Two events can meet in the same cycle: the combinational resolution of a whole window from the current start state, and the register update that starts the next window from the last position. The bench provokes this with back-to-back valid windows, valid windows mixed with idle cycles, and a reset asserted together with a valid window. A behavioural reference machine steps symbol by symbol and checks every position's state and accept flag against the start state it predicts. The start state is checked before it advances, so each check also confirms the one-cycle hand-over from the last position to the next window.

// File: rtl/pfsm_window.sv
module pfsm_window #(
  parameter int NS = 8,
  parameter int SW = 3,
  parameter int AW = 2,
  parameter int W  = 8,
  parameter logic [NS*(1<<AW)*SW-1:0] TRANS = 96'hFAC6_88D1_2B3E_4C75_9A0F_D2E1,
  parameter logic [NS-1:0] ACCEPT = 8'h85
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W*AW-1:0] in_syms,
  output logic [W*SW-1:0] pos_state,
  output logic [W-1:0]    pos_accept,
  output logic [SW-1:0]   start_state
);
  localparam int NA = 1 << AW;
  localparam int LV = $clog2(W);

  typedef logic [W-1:0][NS-1:0][SW-1:0] tabset_t;

  tabset_t cur, nxt;

  always_comb begin
    for (int i = 0; i < W; i++)
      for (int s = 0; s < NS; s++)
        cur[i][s] = TRANS[(s*NA + int'(in_syms[i*AW +: AW]))*SW +: SW];
    nxt = cur;
    for (int k = 0; k < LV; k++) begin
      nxt = cur;
      for (int i = (1 << k); i < W; i++)
        for (int s = 0; s < NS; s++)
          nxt[i][s] = cur[i][cur[i-(1<<k)][s]];
      cur = nxt;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pos
    assign pos_state[i*SW +: SW] = cur[i][start_state];
    assign pos_accept[i]         = ACCEPT[pos_state[i*SW +: SW]];
  end

  always_ff @(posedge clk) begin
    if (rst)
      start_state <= '0;
    else if (in_valid)
      start_state <= pos_state[(W-1)*SW +: SW];
  end
endmodule

// File: rtl/pfsm_window_chk.sv
module pfsm_window_chk #(
  parameter int NS = 8,
  parameter int SW = 3,
  parameter int AW = 2,
  parameter int W  = 8,
  parameter logic [NS*(1<<AW)*SW-1:0] TRANS = '0,
  parameter logic [NS-1:0] ACCEPT = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [W*AW-1:0] in_syms,
  input logic [W*SW-1:0] pos_state,
  input logic [W-1:0]    pos_accept,
  input logic [SW-1:0]   start_state
);
  localparam int NA = 1 << AW;

  function automatic logic [SW-1:0] step(input logic [SW-1:0] s, input logic [AW-1:0] a);
    return TRANS[(int'(s)*NA + int'(a))*SW +: SW];
  endfunction

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q) p_reset_zero_r1: assert (start_state == '0);

  p_first_pos_r2: assert property (@(posedge clk) disable iff (rst)
    pos_state[SW-1:0] == step(start_state, in_syms[AW-1:0]));

  for (genvar i = 1; i < W; i++) begin : g_chain
    p_chain_r3: assert property (@(posedge clk) disable iff (rst)
      pos_state[i*SW +: SW] == step(pos_state[(i-1)*SW +: SW], in_syms[i*AW +: AW]));
  end

  for (genvar i = 0; i < W; i++) begin : g_acc
    p_accept_r4: assert property (@(posedge clk) disable iff (rst)
      pos_accept[i] == ACCEPT[pos_state[i*SW +: SW]]);
  end

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> start_state == $past(pos_state[(W-1)*SW +: SW]));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(start_state));
endmodule

bind pfsm_window pfsm_window_chk #(
  .NS(NS), .SW(SW), .AW(AW), .W(W), .TRANS(TRANS), .ACCEPT(ACCEPT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_syms(in_syms),
  .pos_state(pos_state), .pos_accept(pos_accept), .start_state(start_state)
);

// File: tb/tb_pfsm_window.sv
`timescale 1ns/1ps
module tb_pfsm_window;
  localparam int NS = 8, SW = 3, AW = 2, W = 8;
  localparam logic [NS-1:0] ACC = 8'h85;

  function automatic int nx(input int s, input int a);
    case (a)
      0: return s;
      1: return (s + 1) % 8;
      2: return s ^ 5;
      default: return s >> 1;
    endcase
  endfunction

  function automatic logic [NS*4*SW-1:0] mk_tab();
    logic [NS*4*SW-1:0] t;
    t = '0;
    for (int s = 0; s < NS; s++)
      for (int a = 0; a < 4; a++)
        t[(s*4+a)*SW +: SW] = SW'(nx(s, a));
    return t;
  endfunction

  localparam logic [NS*4*SW-1:0] TT = mk_tab();

  logic clk = 0, rst, in_valid;
  logic [W*AW-1:0] in_syms;
  logic [W*SW-1:0] pos_state;
  logic [W-1:0]    pos_accept;
  logic [SW-1:0]   start_state;

  always #10 clk = ~clk;

  pfsm_window #(.NS(NS), .SW(SW), .AW(AW), .W(W), .TRANS(TT), .ACCEPT(ACC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_syms(in_syms),
    .pos_state(pos_state), .pos_accept(pos_accept), .start_state(start_state));

  int checks = 0, failures = 0;
  int ref_start = 0;
  string stag;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic v, input logic [W*AW-1:0] sy);
    int s;
    rst = r; in_valid = v; in_syms = sy;
    @(negedge clk);
    chk({stag, " start_state"}, int'(start_state), ref_start);
    s = ref_start;
    for (int i = 0; i < W; i++) begin
      s = nx(s, int'(sy[i*AW +: AW]));
      chk(i == 0 ? "R2 pos0 state" : "R3 chained state", int'(pos_state[i*SW +: SW]), s);
      chk("R4 accept flag", int'(pos_accept[i]), int'(ACC[s]));
    end
    if (r) ref_start = 0;
    else if (v) ref_start = s;
    @(posedge clk); #1;
  endtask

  initial begin
    rst = 1; in_valid = 1; in_syms = '0;
    @(posedge clk); #1;
    stag = "R1/R7";
    cycle(1, 1, 16'hB5E3);
    cycle(1, 1, 16'h1234);
    stag = "R6";
    cycle(0, 0, 16'h5A5A);
    cycle(0, 0, 16'hFFFF);
    stag = "R5";
    cycle(0, 1, 16'h0000);
    cycle(0, 1, 16'h5555);
    cycle(0, 1, 16'h4001);
    cycle(0, 1, 16'hAAAA);
    cycle(0, 1, 16'hFFFF);
    cycle(0, 1, 16'h0007);
    stag = "R6";
    cycle(0, 0, 16'h0003);
    stag = "R5/R6";
    for (int n = 0; n < 400; n++)
      cycle(0, ($urandom % 4) != 0, 16'($urandom));
    stag = "R7";
    cycle(1, 1, 16'h4444);
    stag = "R1";
    cycle(0, 1, 16'($urandom));
    stag = "R5";
    for (int n = 0; n < 50; n++)
      cycle(0, 1, 16'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule